// File: doc/BRIEF.md
# CPU Low-Power Mode Controller

This block sequences the power states of a small 8-bit processor between normal running, HALT and SLEEP. The instruction decoder gives it single-cycle pulses when it decodes a halt or a sleep instruction. The block then moves to the matching idle state. It holds that state until a qualified wake request arrives or reset is asserted.

The two idle states behave differently at the pins.

- **HALT** keeps the core clock, the DMA clock and DRAM refresh running. It drives the active-low halt, M1 and status strobes low. It also flags that the opcode fetch is being repeated.
- **SLEEP** gates the clocks to the core and to DMA and stops refresh. It drives only the halt strobe low. It forces the address and control bus high unless an external master holds the bus grant.

A sleep request is honoured only while all three control bits are zero. The modes those bits would select are not built here, so a request with any of them set is dropped.

The wake set also depends on the state.

- **HALT** wakes on NMI, on the on-chip interrupt request, or on an external interrupt line whose enable is set.
- **SLEEP** wakes on NMI, on the on-chip request, or on any external line regardless of its enable.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, the state is normal and every output shows its normal-mode level, without waiting for a clock edge. After `rst_n` rises, instruction pulses take effect again after the reset synchronizer stages.
- R2: In the normal state `state_o` is 00. `core_clk_en`, `dma_clk_en`, `refresh_en`, `halt_n`, `m1_n` and `st_n` are 1, and `bus_force_hi` and `fetch_repeat` are 0.
- R3: In the normal state, a `halt_op` pulse moves the state to halt (`state_o` = 01) at the next clock edge. When `halt_op` and `sleep_op` are both high, halt wins.
- R4: In the halt state the three clock and refresh enables are 1. `halt_n`, `m1_n` and `st_n` are 0, `fetch_repeat` is 1 and `bus_force_hi` is 0.
- R5: In the halt state, the block returns to normal at the next edge when `nmi_req` is high, when `onchip_irq` is high, or when `ext_irq[i]` and `ext_irq_en[i]` are both high for some i. An external line whose enable is clear does not wake it.
- R6: In the normal state, a `sleep_op` pulse with `ctl_bits` = 000 moves the state to sleep (`state_o` = 10) at the next edge. With any `ctl_bits` bit set, the pulse is ignored and the state stays normal.
- R7: In the sleep state the three clock and refresh enables are 0. `halt_n` is 0, `m1_n` and `st_n` are 1, and `fetch_repeat` is 0. `bus_force_hi` equals the inverse of `bus_grant`.
- R8: In the sleep state, the block returns to normal at the next edge when `nmi_req` is high, when `onchip_irq` is high, or when any `ext_irq` line is high, whatever `ext_irq_en` holds.
- R9: In the halt and sleep states, `halt_op` and `sleep_op` pulses do not change the state.
- R10: `state_o` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_op | input | 1 | Pulse: halt instruction decoded |
| sleep_op | input | 1 | Pulse: sleep instruction decoded |
| ctl_bits | input | 3 | I/O-stop bit and two CPU control bits; all must be zero for sleep |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_irq | input | 3 | External interrupt request lines |
| ext_irq_en | input | 3 | Per-line enables for the external requests |
| onchip_irq | input | 1 | Enabled on-chip interrupt request |
| bus_grant | input | 1 | Bus granted to an external master |
| state_o | output | 2 | Power state: 00 normal, 01 halt, 10 sleep |
| core_clk_en | output | 1 | Clock enable for the CPU core |
| dma_clk_en | output | 1 | Clock enable for the DMA channels |
| refresh_en | output | 1 | DRAM refresh enable |
| halt_n | output | 1 | Active-low halt strobe |
| m1_n | output | 1 | Active-low M1 strobe contribution |
| st_n | output | 1 | Active-low status strobe contribution |
| bus_force_hi | output | 1 | Holds address and control lines high |
| fetch_repeat | output | 1 | Opcode fetch is being repeated |

## Verification
A corrupted state register shows up on the same cycle as a wrong `state_o` code. The enables and strobes are decoded directly from that register, so they go wrong on that same cycle too. A wrong wake qualification shows one clock edge after the offending input pattern. The block either stays idle when it should leave, or returns to normal when an unenabled line should have been ignored. The sweeps drive every combination of the wake inputs from both idle states and every control-bit value on sleep entry, so any such error is seen within a single cycle of its cause.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_HALT  = 2'b01,
    ST_SLEEP = 2'b10
  } lpm_state_e;

  // Packed view of the pin-level outputs
  typedef struct packed {
    logic core_clk_en;
    logic dma_clk_en;
    logic refresh_en;
    logic halt_n;
    logic m1_n;
    logic st_n;
    logic bus_force_hi;
    logic fetch_repeat;
  } lpm_pins_t;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int NUM_EXT = 3
) (
  input  logic               nmi_req,
  input  logic               onchip_irq,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  output logic               wake_halt,
  output logic               wake_sleep
);

  logic [NUM_EXT-1:0] ext_qual;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_qual
      assign ext_qual[gi] = ext_irq[gi] & ext_irq_en[gi];
    end
  endgenerate

  // Halt honours the per-line enables; sleep accepts any raw external line
  always_comb begin
    wake_halt  = nmi_req | onchip_irq | (|ext_qual);
    wake_sleep = nmi_req | onchip_irq | (|ext_irq);
  end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_op,
  input  logic       sleep_op,
  input  logic       sleep_ok,
  input  logic       wake_halt,
  input  logic       wake_sleep,
  output lpm_state_e state_q
);

  lpm_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt_op) begin
          state_d = ST_HALT;
        end else if (sleep_op && sleep_ok) begin
          state_d = ST_SLEEP;
        end
      end
      ST_HALT: begin
        if (wake_halt) begin
          state_d = ST_RUN;
        end
      end
      ST_SLEEP: begin
        if (wake_sleep) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       bus_grant,
  output lpm_pins_t  pins
);

  always_comb begin
    pins = '{core_clk_en: 1'b1, dma_clk_en: 1'b1, refresh_en: 1'b1,
             halt_n: 1'b1, m1_n: 1'b1, st_n: 1'b1,
             bus_force_hi: 1'b0, fetch_repeat: 1'b0};
    unique case (state)
      ST_HALT: begin
        pins.halt_n       = 1'b0;
        pins.m1_n         = 1'b0;
        pins.st_n         = 1'b0;
        pins.fetch_repeat = 1'b1;
      end
      ST_SLEEP: begin
        pins.core_clk_en  = 1'b0;
        pins.dma_clk_en   = 1'b0;
        pins.refresh_en   = 1'b0;
        pins.halt_n       = 1'b0;
        pins.bus_force_hi = ~bus_grant;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter int NUM_CTL     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_op,
  input  logic               sleep_op,
  input  logic [NUM_CTL-1:0] ctl_bits,
  input  logic               nmi_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  input  logic               onchip_irq,
  input  logic               bus_grant,
  output logic [1:0]         state_o,
  output logic               core_clk_en,
  output logic               dma_clk_en,
  output logic               refresh_en,
  output logic               halt_n,
  output logic               m1_n,
  output logic               st_n,
  output logic               bus_force_hi,
  output logic               fetch_repeat
);

  logic       rst_core_n;
  logic       wake_halt;
  logic       wake_sleep;
  logic       sleep_ok;
  lpm_state_e state;
  lpm_pins_t  pins;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lpm_wake #(.NUM_EXT(NUM_EXT)) u_wake (
    .nmi_req    (nmi_req),
    .onchip_irq (onchip_irq),
    .ext_irq    (ext_irq),
    .ext_irq_en (ext_irq_en),
    .wake_halt  (wake_halt),
    .wake_sleep (wake_sleep)
  );

  assign sleep_ok = ~|ctl_bits;

  lpm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .halt_op    (halt_op),
    .sleep_op   (sleep_op),
    .sleep_ok   (sleep_ok),
    .wake_halt  (wake_halt),
    .wake_sleep (wake_sleep),
    .state_q    (state)
  );

  lpm_outdec u_outdec (
    .state     (state),
    .bus_grant (bus_grant),
    .pins      (pins)
  );

  assign state_o      = state;
  assign core_clk_en  = pins.core_clk_en;
  assign dma_clk_en   = pins.dma_clk_en;
  assign refresh_en   = pins.refresh_en;
  assign halt_n       = pins.halt_n;
  assign m1_n         = pins.m1_n;
  assign st_n         = pins.st_n;
  assign bus_force_hi = pins.bus_force_hi;
  assign fetch_repeat = pins.fetch_repeat;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NUM_EXT = 3,
  parameter int NUM_CTL = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halt_op,
  input logic               sleep_op,
  input logic [NUM_CTL-1:0] ctl_bits,
  input logic               nmi_req,
  input logic [NUM_EXT-1:0] ext_irq,
  input logic               onchip_irq,
  input logic               bus_grant,
  input logic [1:0]         state_o,
  input logic               core_clk_en,
  input logic               dma_clk_en,
  input logic               refresh_en,
  input logic               halt_n,
  input logic               m1_n,
  input logic               st_n,
  input logic               bus_force_hi,
  input logic               fetch_repeat
);

  a_r4_halt_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01) |-> (!halt_n && !m1_n && !st_n && fetch_repeat && core_clk_en && refresh_en));

  a_r7_sleep_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10) |-> (!core_clk_en && !dma_clk_en && !refresh_en && !halt_n && (bus_force_hi == !bus_grant)));

  a_r5_halt_nmi_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && nmi_req) |=> (state_o == 2'b00));

  a_r8_sleep_ext_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && (|ext_irq || onchip_irq)) |=> (state_o == 2'b00));

  a_r6_sleep_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sleep_op && !halt_op && (|ctl_bits)) |=> (state_o == 2'b00));

  a_r10_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_EXT(NUM_EXT), .NUM_CTL(NUM_CTL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_op      (halt_op),
  .sleep_op     (sleep_op),
  .ctl_bits     (ctl_bits),
  .nmi_req      (nmi_req),
  .ext_irq      (ext_irq),
  .onchip_irq   (onchip_irq),
  .bus_grant    (bus_grant),
  .state_o      (state_o),
  .core_clk_en  (core_clk_en),
  .dma_clk_en   (dma_clk_en),
  .refresh_en   (refresh_en),
  .halt_n       (halt_n),
  .m1_n         (m1_n),
  .st_n         (st_n),
  .bus_force_hi (bus_force_hi),
  .fetch_repeat (fetch_repeat)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_op = 1'b0;
  logic       sleep_op = 1'b0;
  logic [2:0] ctl_bits = 3'b000;
  logic       nmi_req = 1'b0;
  logic [2:0] ext_irq = 3'b000;
  logic [2:0] ext_irq_en = 3'b000;
  logic       onchip_irq = 1'b0;
  logic       bus_grant = 1'b0;
  logic [1:0] state_o;
  logic       core_clk_en, dma_clk_en, refresh_en, halt_n, m1_n, st_n;
  logic       bus_force_hi, fetch_repeat;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  localparam logic [1:0] S_RUN   = 2'b00;
  localparam logic [1:0] S_HALT  = 2'b01;
  localparam logic [1:0] S_SLEEP = 2'b10;

  always #4 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_op(halt_op), .sleep_op(sleep_op),
    .ctl_bits(ctl_bits), .nmi_req(nmi_req), .ext_irq(ext_irq),
    .ext_irq_en(ext_irq_en), .onchip_irq(onchip_irq), .bus_grant(bus_grant),
    .state_o(state_o), .core_clk_en(core_clk_en), .dma_clk_en(dma_clk_en),
    .refresh_en(refresh_en), .halt_n(halt_n), .m1_n(m1_n), .st_n(st_n),
    .bus_force_hi(bus_force_hi), .fetch_repeat(fetch_repeat)
  );

  // Expected {state, core, dma, refresh, halt_n, m1_n, st_n, force_hi, repeat}
  function automatic logic [9:0] exp_vec(input logic [1:0] s, input logic bg);
    case (s)
      S_HALT:  exp_vec = {S_HALT,  8'b1110_0001};
      S_SLEEP: exp_vec = {S_SLEEP, 3'b000, 3'b011, ~bg, 1'b0};
      default: exp_vec = {S_RUN,   8'b1111_1100};
    endcase
  endfunction

  task automatic chk(input string req, input logic [1:0] s);
    logic [9:0] act;
    logic [9:0] exp;
    act = {state_o, core_clk_en, dma_clk_en, refresh_en, halt_n, m1_n, st_n,
           bus_force_hi, fetch_repeat};
    exp = exp_vec(s, bus_grant);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a negedge in the normal state; returns at a negedge
  task automatic enter(input logic [1:0] s);
    if (s == S_HALT) halt_op = 1'b1;
    else begin
      ctl_bits = 3'b000;
      sleep_op = 1'b1;
    end
    @(negedge clk);
    halt_op  = 1'b0;
    sleep_op = 1'b0;
  endtask

  task automatic leave();
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", S_RUN);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", S_RUN);

    // R3 / R4: halt entry and pins
    enter(S_HALT);
    chk("R3", S_HALT);
    chk("R4", S_HALT);
    leave();
    chk("R5", S_RUN);

    // R3: halt has priority over sleep
    halt_op = 1'b1; sleep_op = 1'b1; ctl_bits = 3'b000;
    @(negedge clk);
    halt_op = 1'b0; sleep_op = 1'b0;
    chk("R3", S_HALT);
    leave();

    // R6: sleep entry against every control value
    for (int c = 0; c < 8; c++) begin
      ctl_bits = c[2:0];
      sleep_op = 1'b1;
      @(negedge clk);
      sleep_op = 1'b0;
      ctl_bits = 3'b000;
      chk("R6", (c == 0) ? S_SLEEP : S_RUN);
      if (c == 0) leave();
    end

    // R7: bus force follows grant in sleep
    enter(S_SLEEP);
    for (int g = 0; g < 2; g++) begin
      bus_grant = g[0];
      #1;
      chk("R7", S_SLEEP);
      @(negedge clk);
    end
    bus_grant = 1'b0;

    // R9: instruction pulses ignored in sleep, then in halt
    halt_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0;
    chk("R9", S_SLEEP);
    leave();
    enter(S_HALT);
    sleep_op = 1'b1;
    @(negedge clk);
    sleep_op = 1'b0;
    chk("R9", S_HALT);
    halt_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0;
    chk("R9", S_HALT);
    leave();

    // R5 / R8: exhaustive wake sweep from both idle states
    for (int st = 1; st <= 2; st++) begin
      for (int v = 0; v < 256; v++) begin
        logic [1:0] sv;
        logic       wake;
        sv = st[1:0];
        enter(sv);
        nmi_req    = v[0];
        onchip_irq = v[1];
        ext_irq    = v[4:2];
        ext_irq_en = v[7:5];
        bus_grant  = v[7] ^ v[2];
        if (sv == S_HALT) wake = v[0] | v[1] | (|(v[4:2] & v[7:5]));
        else              wake = v[0] | v[1] | (|v[4:2]);
        @(negedge clk);
        chk((sv == S_HALT) ? "R5" : "R8", wake ? S_RUN : sv);
        nmi_req = 1'b0; onchip_irq = 1'b0; ext_irq = 3'b000;
        ext_irq_en = 3'b000; bus_grant = 1'b0;
        if (!wake) leave();
      end
    end

    // R1: asynchronous reset from sleep
    enter(S_SLEEP);
    #2 rst_n = 1'b0;
    #1 chk("R1", S_RUN);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: pulse inside the synchroniser window is blocked
    halt_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0;
    chk("R1", S_RUN);
    repeat (3) @(negedge clk);
    enter(S_HALT);
    chk("R1", S_HALT);
    leave();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule